// File: doc/BRIEF.md
# Set-Associative Cache with Selectable Write Policy

This block sits between a processor-side request port and a next-level memory port. Each request carries a word address. The address is split into three fields. The low bits select a word within a line. The middle bits select a set. The remaining high bits form the tag that is stored with each line. Every set holds a fixed number of ways. Each way keeps a valid bit, a tag and a full line of data, plus a dirty bit when write-back mode is built. A miss or a write-through store talks to the next level through a single-request port. The cache issues a one-cycle request there and then waits for a one-cycle response. Only one memory request is outstanding at any time.

Two compile-time switches set the write behaviour, and they are independent of each other. `WRITE_ALLOCATE` decides whether a write miss brings the line in first. `WRITE_BACK` decides whether a write hit stays local and marks the line dirty, or is also sent to the next level. Replacement within a set follows true least-recently-used order. Each set keeps an age rank for every way.

Top module: `setassoc_cache`

## Requirements
- R1: A word address splits into offset (low log2(LINE_WORDS) bits), set index (next log2(SETS) bits) and tag (the rest). Addresses in one line share a fill. Addresses that differ by a multiple of SETS*LINE_WORDS words compete for the same set.
- R2: A read hit answers with `resp_valid` high for one cycle and `resp_hit`=1. It returns the most recently written value of that word and makes no memory request. The answer comes in the second cycle after the request is accepted.
- R3: A miss that allocates fetches the whole line with a line read (`mem_req_line`=1, `mem_req_write`=0, line-aligned address). If the victim is valid and dirty, a line write of the victim is issued first and acknowledged before the line read is issued. A clean victim is never written back.
- R4: The victim in a set is the least recently used way, and every hit or fill makes the accessed way the most recent. So cycling over WAYS lines in one set misses only on first touch. Cycling over WAYS+1 lines misses every time.
- R5: With `WRITE_ALLOCATE`=1, a write miss first fills the line as in R3. It then completes as a write hit under the selected hit policy, and responds with `resp_hit`=0.
- R6: With `WRITE_ALLOCATE`=0, a write miss sends one word write (`mem_req_line`=0, `mem_req_write`=1, data in the low `DATA_W` bits). It leaves the cache contents and ages unchanged, so a later read of that word misses.
- R7: With `WRITE_BACK`=1, a write hit updates the cached word and marks the line dirty, with no memory request. The data reaches the next level only when that line is evicted.
- R8: With `WRITE_BACK`=0, every write hit also sends one word write to the next level. No line write is ever issued.
- R9: After reset, all lines are invalid, `req_ready` is 1, and `resp_valid` and `mem_req_valid` are 0.
- R10: At most one memory request is outstanding. `mem_req_valid` is never raised while a previous request awaits `mem_resp_valid`, nor while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | Request hit without memory fetch |
| resp_rdata | output | DATA_W | Load data (zero for stores) |
| mem_req_valid | output | 1 | One-cycle memory request pulse |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_line | output | 1 | 1 = whole line, 0 = single word |
| mem_req_addr | output | ADDR_W | Word address (line-aligned for line requests) |
| mem_req_wdata | output | DATA_W*LINE_WORDS | Write data (word in low bits for word writes) |
| mem_resp_valid | input | 1 | One-cycle memory completion |
| mem_resp_rdata | input | DATA_W*LINE_WORDS | Line data for a line read |

## Verification
A corrupted tag, valid bit or age rank shows up as a wrong `resp_hit` on the very next access to that set. A stale or lost data word shows up as a wrong `resp_rdata` on the next load of that word. Under write-back, the fault may only appear after the dirty line has been evicted and fetched again. A missing or extra dirty bit shows up as a wrong number of line writes on the eviction that follows. The bench checks all of these per access, against a model for each policy pair, across strided same-set patterns.

// File: rtl/cache_pkg.sv
// Shared types for the set-associative cache.
package cache_pkg;

    // Controller states: idle, tag compare, victim writeback, line fill, word write.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOOKUP = 3'd1,
        ST_EVICT  = 3'd2,
        ST_FILL   = 3'd3,
        ST_WORD   = 3'd4
    } cache_state_e;

endpackage

// File: rtl/cache_lru.sv
// Per-set true-LRU age ranks.
// Rank 0 is the most recent way and rank WAYS-1 the least recent. Reset gives
// way w the rank w. Assumes WAYS and SETS are powers of two, both at least 2.
module cache_lru #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int IDX_W = 2,
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] victim_way
);

    logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] all_rank;

    for (genvar s = 0; s < SETS; s++) begin : g_set
        logic [WAYS-1:0][WAY_W-1:0] rank_q;

        // Age update: touched way becomes newest, younger ways age by one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int w = 0; w < WAYS; w++) rank_q[w] <= WAY_W'(w);
            end else if (touch_en && idx == IDX_W'(s)) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (WAY_W'(w) == touch_way)
                        rank_q[w] <= '0;
                    else if (rank_q[w] < rank_q[touch_way])
                        rank_q[w] <= rank_q[w] + 1'b1;
                end
            end
        end

        assign all_rank[s] = rank_q;
    end

    // Victim pick: the way holding the oldest rank in the addressed set.
    always_comb begin
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (all_rank[idx][w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/cache_arrays.sv
// Line storage: valid bits, tags, data and (in write-back builds) dirty bits.
// Reads are combinational for the whole addressed set. Fill and word write
// both use the same set index as the read port. Assumes the controller never
// fills and word-writes in the same cycle.
module cache_arrays #(
    parameter int SETS       = 4,
    parameter int WAYS       = 4,
    parameter int IDX_W      = 2,
    parameter int WAY_W      = 2,
    parameter int OFF_W      = 2,
    parameter int TAG_W      = 8,
    parameter int DATA_W     = 32,
    parameter int LINE_W     = 128,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IDX_W-1:0]             idx,
    output logic [WAYS-1:0]              set_valid,
    output logic [WAYS-1:0]              set_dirty,
    output logic [WAYS-1:0][TAG_W-1:0]   set_tag,
    output logic [WAYS-1:0][LINE_W-1:0]  set_line,
    input  logic                         fill_en,
    input  logic [WAY_W-1:0]             fill_way,
    input  logic [TAG_W-1:0]             fill_tag,
    input  logic [LINE_W-1:0]            fill_line,
    input  logic                         wr_en,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic [OFF_W-1:0]             wr_off,
    input  logic [DATA_W-1:0]            wr_word
);

    logic [WAYS-1:0]   valid_q [SETS];
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [LINE_W-1:0] data_q  [SETS][WAYS];

    // Valid and tag: cleared valid on reset, set on fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (fill_en) begin
            valid_q[idx][fill_way] <= 1'b1;
            tag_q[idx][fill_way]   <= fill_tag;
        end
    end

    // Data: whole-line fill or single-word store.
    always_ff @(posedge clk) begin
        if (fill_en)
            data_q[idx][fill_way] <= fill_line;
        else if (wr_en)
            data_q[idx][wr_way][wr_off*DATA_W +: DATA_W] <= wr_word;
    end

    // Set read: present every way of the addressed set.
    always_comb begin
        set_valid = valid_q[idx];
        for (int w = 0; w < WAYS; w++) begin
            set_tag[w]  = tag_q[idx][w];
            set_line[w] = data_q[idx][w];
        end
    end

    if (WRITE_BACK) begin : g_dirty
        logic [WAYS-1:0] dirty_q [SETS];

        // Dirty tracking: cleared by fill, set by a local store.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) dirty_q[s] <= '0;
            end else if (fill_en) begin
                dirty_q[idx][fill_way] <= 1'b0;
            end else if (wr_en) begin
                dirty_q[idx][wr_way] <= 1'b1;
            end
        end

        assign set_dirty = dirty_q[idx];
    end else begin : g_no_dirty
        assign set_dirty = '0;
    end

endmodule

// File: rtl/cache_ctrl.sv
// Request sequencer: tag compare, victim writeback, line fill, word write.
// Accepts one processor request in idle, handles at most one memory request
// at a time, and replays the lookup after every fill so the access finishes
// as a hit. Assumes the memory answers every request exactly once.
module cache_ctrl
    import cache_pkg::*;
#(
    parameter int ADDR_W         = 12,
    parameter int DATA_W         = 32,
    parameter int WAYS           = 4,
    parameter int IDX_W          = 2,
    parameter int WAY_W          = 2,
    parameter int OFF_W          = 2,
    parameter int TAG_W          = 8,
    parameter int LINE_W         = 128,
    parameter bit WRITE_ALLOCATE = 1'b1,
    parameter bit WRITE_BACK     = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [DATA_W-1:0]           req_wdata,
    output logic                        resp_valid,
    output logic                        resp_hit,
    output logic [DATA_W-1:0]           resp_rdata,
    output logic                        mem_req_valid,
    output logic                        mem_req_write,
    output logic                        mem_req_line,
    output logic [ADDR_W-1:0]           mem_req_addr,
    output logic [LINE_W-1:0]           mem_req_wdata,
    input  logic                        mem_resp_valid,
    input  logic [LINE_W-1:0]           mem_resp_rdata,
    output logic [IDX_W-1:0]            look_idx,
    input  logic [WAYS-1:0]             set_valid,
    input  logic [WAYS-1:0]             set_dirty,
    input  logic [WAYS-1:0][TAG_W-1:0]  set_tag,
    input  logic [WAYS-1:0][LINE_W-1:0] set_line,
    input  logic [WAY_W-1:0]            victim_way,
    output logic                        fill_en,
    output logic [WAY_W-1:0]            fill_way,
    output logic [TAG_W-1:0]            fill_tag,
    output logic [LINE_W-1:0]           fill_line,
    output logic                        wr_en,
    output logic [WAY_W-1:0]            wr_way,
    output logic [OFF_W-1:0]            wr_off,
    output logic [DATA_W-1:0]           wr_word,
    output logic                        touch_en,
    output logic [WAY_W-1:0]            touch_way,
    output logic                        alloc_go
);

    cache_state_e        state_q;
    logic [ADDR_W-1:0]   addr_q;
    logic                write_q;
    logic [DATA_W-1:0]   wdata_q;
    logic                missed_q;
    logic [WAY_W-1:0]    way_q;

    logic [TAG_W-1:0]    tag_a;
    logic [IDX_W-1:0]    idx_a;
    logic [OFF_W-1:0]    off_a;
    logic                hit;
    logic [WAY_W-1:0]    hit_way;
    logic [DATA_W-1:0]   hit_word;
    logic                in_lookup;

    assign off_a = addr_q[OFF_W-1:0];
    assign idx_a = addr_q[OFF_W +: IDX_W];
    assign tag_a = addr_q[ADDR_W-1 -: TAG_W];
    assign in_lookup = (state_q == ST_LOOKUP);

    // Tag compare across all ways of the latched set.
    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (set_valid[w] && set_tag[w] == tag_a) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
        hit_word = set_line[hit_way][off_a*DATA_W +: DATA_W];
    end

    // Array and age controls derived from the current state.
    always_comb begin
        look_idx  = idx_a;
        touch_en  = in_lookup && hit;
        touch_way = hit_way;
        wr_en     = in_lookup && hit && write_q;
        wr_way    = hit_way;
        wr_off    = off_a;
        wr_word   = wdata_q;
        fill_en   = (state_q == ST_FILL) && mem_resp_valid;
        fill_way  = way_q;
        fill_tag  = tag_a;
        fill_line = mem_resp_rdata;
        alloc_go  = in_lookup && !hit && (!write_q || WRITE_ALLOCATE);
    end

    assign req_ready = (state_q == ST_IDLE);

    // Sequencer: state, latched request, response and memory request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            addr_q        <= '0;
            write_q       <= 1'b0;
            wdata_q       <= '0;
            missed_q      <= 1'b0;
            way_q         <= '0;
            resp_valid    <= 1'b0;
            resp_hit      <= 1'b0;
            resp_rdata    <= '0;
            mem_req_valid <= 1'b0;
            mem_req_write <= 1'b0;
            mem_req_line  <= 1'b0;
            mem_req_addr  <= '0;
            mem_req_wdata <= '0;
        end else begin
            resp_valid    <= 1'b0;
            mem_req_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q   <= req_addr;
                        write_q  <= req_write;
                        wdata_q  <= req_wdata;
                        missed_q <= 1'b0;
                        state_q  <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (hit && !write_q) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= !missed_q;
                        resp_rdata <= hit_word;
                        state_q    <= ST_IDLE;
                    end else if (hit && WRITE_BACK) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= !missed_q;
                        resp_rdata <= '0;
                        state_q    <= ST_IDLE;
                    end else if (hit || !alloc_go) begin
                        missed_q      <= missed_q | !hit;
                        mem_req_valid <= 1'b1;
                        mem_req_write <= 1'b1;
                        mem_req_line  <= 1'b0;
                        mem_req_addr  <= addr_q;
                        mem_req_wdata <= {{(LINE_W-DATA_W){1'b0}}, wdata_q};
                        state_q       <= ST_WORD;
                    end else begin
                        missed_q      <= 1'b1;
                        way_q         <= victim_way;
                        mem_req_valid <= 1'b1;
                        mem_req_line  <= 1'b1;
                        if (set_valid[victim_way] && set_dirty[victim_way]) begin
                            mem_req_write <= 1'b1;
                            mem_req_addr  <= {set_tag[victim_way], idx_a, {OFF_W{1'b0}}};
                            mem_req_wdata <= set_line[victim_way];
                            state_q       <= ST_EVICT;
                        end else begin
                            mem_req_write <= 1'b0;
                            mem_req_addr  <= {tag_a, idx_a, {OFF_W{1'b0}}};
                            state_q       <= ST_FILL;
                        end
                    end
                end
                ST_EVICT: begin
                    if (mem_resp_valid) begin
                        mem_req_valid <= 1'b1;
                        mem_req_write <= 1'b0;
                        mem_req_line  <= 1'b1;
                        mem_req_addr  <= {tag_a, idx_a, {OFF_W{1'b0}}};
                        state_q       <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_resp_valid) state_q <= ST_LOOKUP;
                end
                ST_WORD: begin
                    if (mem_resp_valid) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= !missed_q;
                        resp_rdata <= '0;
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/setassoc_cache.sv
// Top of the set-associative cache: joins sequencer, line storage and ages.
// Write behaviour is fixed at build time by WRITE_ALLOCATE and WRITE_BACK.
// Assumes ADDR_W > log2(SETS) + log2(LINE_WORDS) and power-of-two SETS,
// WAYS and LINE_WORDS, each at least 2.
module setassoc_cache #(
    parameter int ADDR_W         = 12,
    parameter int DATA_W         = 32,
    parameter int LINE_WORDS     = 4,
    parameter int SETS           = 4,
    parameter int WAYS           = 4,
    parameter bit WRITE_ALLOCATE = 1'b1,
    parameter bit WRITE_BACK     = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic                           req_write,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [DATA_W-1:0]              req_wdata,
    output logic                           resp_valid,
    output logic                           resp_hit,
    output logic [DATA_W-1:0]              resp_rdata,
    output logic                           mem_req_valid,
    output logic                           mem_req_write,
    output logic                           mem_req_line,
    output logic [ADDR_W-1:0]              mem_req_addr,
    output logic [DATA_W*LINE_WORDS-1:0]   mem_req_wdata,
    input  logic                           mem_resp_valid,
    input  logic [DATA_W*LINE_WORDS-1:0]   mem_resp_rdata
);

    localparam int OFF_W  = $clog2(LINE_WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W = DATA_W * LINE_WORDS;

    logic [IDX_W-1:0]            look_idx;
    logic [WAYS-1:0]             set_valid;
    logic [WAYS-1:0]             set_dirty;
    logic [WAYS-1:0][TAG_W-1:0]  set_tag;
    logic [WAYS-1:0][LINE_W-1:0] set_line;
    logic [WAY_W-1:0]            victim_way;
    logic                        fill_en;
    logic [WAY_W-1:0]            fill_way;
    logic [TAG_W-1:0]            fill_tag;
    logic [LINE_W-1:0]           fill_line;
    logic                        wr_en;
    logic [WAY_W-1:0]            wr_way;
    logic [OFF_W-1:0]            wr_off;
    logic [DATA_W-1:0]           wr_word;
    logic                        touch_en;
    logic [WAY_W-1:0]            touch_way;
    logic                        alloc_go;

    cache_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(WAYS), .IDX_W(IDX_W),
        .WAY_W(WAY_W), .OFF_W(OFF_W), .TAG_W(TAG_W), .LINE_W(LINE_W),
        .WRITE_ALLOCATE(WRITE_ALLOCATE), .WRITE_BACK(WRITE_BACK)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_line(mem_req_line), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_resp_valid(mem_resp_valid),
        .mem_resp_rdata(mem_resp_rdata),
        .look_idx(look_idx), .set_valid(set_valid), .set_dirty(set_dirty),
        .set_tag(set_tag), .set_line(set_line), .victim_way(victim_way),
        .fill_en(fill_en), .fill_way(fill_way), .fill_tag(fill_tag),
        .fill_line(fill_line), .wr_en(wr_en), .wr_way(wr_way),
        .wr_off(wr_off), .wr_word(wr_word), .touch_en(touch_en),
        .touch_way(touch_way), .alloc_go(alloc_go)
    );

    cache_arrays #(
        .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W), .OFF_W(OFF_W),
        .TAG_W(TAG_W), .DATA_W(DATA_W), .LINE_W(LINE_W), .WRITE_BACK(WRITE_BACK)
    ) u_arrays (
        .clk(clk), .rst_n(rst_n), .idx(look_idx),
        .set_valid(set_valid), .set_dirty(set_dirty), .set_tag(set_tag),
        .set_line(set_line), .fill_en(fill_en), .fill_way(fill_way),
        .fill_tag(fill_tag), .fill_line(fill_line), .wr_en(wr_en),
        .wr_way(wr_way), .wr_off(wr_off), .wr_word(wr_word)
    );

    cache_lru #(
        .SETS(SETS), .WAYS(WAYS), .IDX_W(IDX_W), .WAY_W(WAY_W)
    ) u_lru (
        .clk(clk), .rst_n(rst_n), .idx(look_idx), .touch_en(touch_en),
        .touch_way(touch_way), .victim_way(victim_way)
    );

endmodule

// File: rtl/setassoc_cache_chk.sv
// Protocol and policy checker bound to setassoc_cache.
// Watches the ports plus the allocation pulse, set valid bits and victim choice.
module setassoc_cache_chk #(
    parameter int WAYS       = 4,
    parameter int WAY_W      = 2,
    parameter bit WRITE_BACK = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             req_write,
    input logic             resp_valid,
    input logic             resp_hit,
    input logic             mem_req_valid,
    input logic             mem_req_write,
    input logic             mem_req_line,
    input logic             mem_resp_valid,
    input logic             alloc_go,
    input logic [WAYS-1:0]  set_valid,
    input logic [WAY_W-1:0] victim_way
);

    logic busy_q;
    logic seen_q;
    logic wr_q;
    logic prev_wb_q;

    // Tracking: outstanding memory request, traffic since accept, last kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            seen_q    <= 1'b0;
            wr_q      <= 1'b0;
            prev_wb_q <= 1'b0;
        end else begin
            if (mem_req_valid)       busy_q <= 1'b1;
            else if (mem_resp_valid) busy_q <= 1'b0;
            if (req_valid && req_ready) begin
                seen_q <= 1'b0;
                wr_q   <= req_write;
            end else if (mem_req_valid) begin
                seen_q <= 1'b1;
            end
            if (mem_req_valid) prev_wb_q <= mem_req_write && mem_req_line;
        end
    end

    // R10
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !busy_q);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && req_ready));

    // R2
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R2
    hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_hit && !(wr_q && !WRITE_BACK)) |-> !seen_q);

    // R3
    miss_has_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> seen_q);

    // R3
    fill_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && prev_wb_q) |-> (mem_req_line && !mem_req_write));

    // R4
    invalid_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_go && !(&set_valid)) |-> !set_valid[victim_way]);

    if (!WRITE_BACK) begin : g_wt
        // R8
        no_line_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_req_valid && mem_req_write) |-> !mem_req_line);
    end

endmodule

bind setassoc_cache setassoc_cache_chk #(
    .WAYS(WAYS), .WAY_W(WAY_W), .WRITE_BACK(WRITE_BACK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_line(mem_req_line), .mem_resp_valid(mem_resp_valid),
    .alloc_go(alloc_go), .set_valid(set_valid), .victim_way(victim_way)
);

// File: tb/setassoc_cache_tb.sv
// One policy build of the cache with its memory model and reference model.
module setassoc_cache_run #(
    parameter bit WA = 1'b1,
    parameter bit WB = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    output logic done,
    output int   errors,
    output int   checks
);
    localparam int ADDR_W = 12;
    localparam int DW     = 32;
    localparam int WORDS  = 4;
    localparam int SETS   = 4;
    localparam int WAYS   = 4;
    localparam int LW     = DW * WORDS;
    localparam int MEMSZ  = 1 << ADDR_W;
    localparam int STRIDE = SETS * WORDS;
    localparam int LAT    = 3;

    logic              req_valid, req_ready, req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [DW-1:0]     req_wdata;
    logic              resp_valid, resp_hit;
    logic [DW-1:0]     resp_rdata;
    logic              mem_req_valid, mem_req_write, mem_req_line;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [LW-1:0]     mem_req_wdata;
    logic              mem_resp_valid;
    logic [LW-1:0]     mem_resp_rdata;

    setassoc_cache #(
        .ADDR_W(ADDR_W), .DATA_W(DW), .LINE_WORDS(WORDS), .SETS(SETS),
        .WAYS(WAYS), .WRITE_ALLOCATE(WA), .WRITE_BACK(WB)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_line(mem_req_line), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_resp_valid(mem_resp_valid),
        .mem_resp_rdata(mem_resp_rdata)
    );

    // Next-level memory with fixed latency and traffic counters.
    logic [DW-1:0] backing [MEMSZ];
    logic [DW-1:0] golden  [MEMSZ];
    int n_lwr, n_lrd, n_wwr, overlap, cyc, t_wb, t_fill, cnt;
    bit busy;
    logic [LW-1:0] line_q;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < MEMSZ; i++) backing[i] = 32'hA500_0000 + i * 3;
            n_lwr = 0; n_lrd = 0; n_wwr = 0; overlap = 0; cyc = 0;
            t_wb = 0; t_fill = 0; cnt = 0; busy = 0;
            mem_resp_valid <= 1'b0;
            mem_resp_rdata <= '0;
        end else begin
            int base;
            cyc++;
            mem_resp_valid <= 1'b0;
            if (mem_req_valid) begin
                if (busy) overlap++;
                busy = 1;
                cnt  = LAT;
                base = int'(mem_req_addr) & ~(WORDS - 1);
                if (mem_req_write && mem_req_line) begin
                    n_lwr++; t_wb = cyc;
                    for (int k = 0; k < WORDS; k++) backing[base + k] = mem_req_wdata[k*DW +: DW];
                end else if (mem_req_write) begin
                    n_wwr++;
                    backing[int'(mem_req_addr)] = mem_req_wdata[DW-1:0];
                end else begin
                    n_lrd++; t_fill = cyc;
                end
                for (int k = 0; k < WORDS; k++) line_q[k*DW +: DW] = backing[base + k];
            end else if (busy) begin
                cnt--;
                if (cnt == 0) begin
                    busy = 0;
                    mem_resp_valid <= 1'b1;
                    mem_resp_rdata <= line_q;
                end
            end
        end
    end

    // Reference model state.
    bit m_valid [SETS][WAYS];
    bit m_dirty [SETS][WAYS];
    int m_tag   [SETS][WAYS];
    int m_rank  [SETS][WAYS];
    int hits_seen;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s (WA=%0d WB=%0d): actual=%0h expected=%0h", req, what, WA, WB, act, exp);
        end
    endtask

    task automatic model_touch(input int s, input int way);
        int r = m_rank[s][way];
        for (int w = 0; w < WAYS; w++) begin
            if (w == way) m_rank[s][w] = 0;
            else if (m_rank[s][w] < r) m_rank[s][w]++;
        end
    endtask

    task automatic model_access(input int addr, input bit wr, output bit hit,
                                output int e_wb, output int e_fill, output int e_word);
        int s = (addr / WORDS) % SETS;
        int t = addr / STRIDE;
        int way = -1;
        hit = 0; e_wb = 0; e_fill = 0; e_word = 0;
        for (int w = 0; w < WAYS; w++)
            if (m_valid[s][w] && m_tag[s][w] == t) begin hit = 1; way = w; end
        if (!hit && (!wr || WA)) begin
            for (int w = 0; w < WAYS; w++) if (m_rank[s][w] == WAYS - 1) way = w;
            if (m_valid[s][way] && m_dirty[s][way]) e_wb = 1;
            e_fill = 1;
            m_valid[s][way] = 1; m_tag[s][way] = t; m_dirty[s][way] = 0;
        end
        if (way >= 0) begin
            model_touch(s, way);
            if (wr) begin
                if (WB) m_dirty[s][way] = 1;
                else e_word = 1;
            end
        end else begin
            e_word = 1;
        end
    endtask

    task automatic access(input int addr, input bit wr, input int data, input string tag);
        bit eh; int ewb, efl, ewd, b_lwr, b_lrd, b_wwr, n;
        string r;
        model_access(addr, wr, eh, ewb, efl, ewd);
        if (tag != "") r = tag;
        else if (ewb != 0) r = "R3";
        else if (wr && !eh) r = WA ? "R5" : "R6";
        else if (wr) r = WB ? "R7" : "R8";
        else r = "R2";
        if (wr) golden[addr] = data;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        b_lwr = n_lwr; b_lrd = n_lrd; b_wwr = n_wwr;
        req_valid = 1; req_write = wr; req_addr = ADDR_W'(addr); req_wdata = data;
        @(negedge clk);
        req_valid = 0;
        n = 0;
        while (!resp_valid && n < 100) begin @(negedge clk); n++; end
        chk(r, "response seen", resp_valid, 1);
        chk(r, "hit flag", resp_hit, eh);
        if (resp_hit) hits_seen++;
        if (!wr) chk(r, "read data", resp_rdata, golden[addr]);
        chk(r, "line writes", n_lwr - b_lwr, ewb);
        chk(r, "line reads", n_lrd - b_lrd, efl);
        chk(r, "word writes", n_wwr - b_wwr, ewd);
        if (ewb != 0) chk("R3", "writeback before fill", t_wb < t_fill, 1);
    endtask

    initial begin
        int h0;
        done = 0; errors = 0; checks = 0; hits_seen = 0;
        req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        for (int i = 0; i < MEMSZ; i++) golden[i] = 32'hA500_0000 + i * 3;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 0; m_dirty[s][w] = 0; m_tag[s][w] = 0; m_rank[s][w] = w;
            end
        while (!rst_n) @(negedge clk);
        @(negedge clk);
        // R9: idle after reset
        chk("R9", "req_ready after reset", req_ready, 1);
        chk("R9", "resp_valid after reset", resp_valid, 0);
        chk("R9", "mem_req_valid after reset", mem_req_valid, 0);

        // R1: field split, same line shares fill, stride hits same set
        access(12'h005, 0, 0, "R1");
        access(12'h006, 0, 0, "R1");
        access(12'h005 + STRIDE, 0, 0, "R1");
        access(12'h009, 0, 0, "R1");
        access(12'h007, 0, 0, "R1");

        // R4: WAYS lines cycled three times in set 0 -> misses only first round
        h0 = hits_seen;
        for (int rd = 0; rd < 3; rd++)
            for (int k = 0; k < WAYS; k++) access(12'h100 + k * STRIDE, 0, 0, "R4");
        chk("R4", "hits for WAYS-line cycle", hits_seen - h0, 2 * WAYS);
        // R4: WAYS+1 lines cycled twice in set 2 -> every access misses
        h0 = hits_seen;
        for (int rd = 0; rd < 2; rd++)
            for (int k = 0; k <= WAYS; k++) access(12'h208 + k * STRIDE, 0, 0, "R4");
        chk("R4", "hits for WAYS+1-line cycle", hits_seen - h0, 0);

        // Write policies in set 3: miss, readback, hit, then dirty eviction
        access(12'h30C, 1, 32'h1111_0001, "");
        access(12'h30C, 0, 0, "");
        access(12'h30D, 1, 32'h2222_0002, "");
        access(12'h30C, 1, 32'h3333_0003, "");
        for (int k = 1; k <= WAYS; k++) access(12'h30C + k * STRIDE, 0, 0, "");
        access(12'h30C, 0, 0, "");
        access(12'h30D, 0, 0, "");

        // Strided mixed sweep across all sets
        for (int i = 0; i < 240; i++) begin
            int a = ((i % 6) * STRIDE + ((i / 6) % SETS) * WORDS + (i % 3) + 12'h400) % MEMSZ;
            access(a, (i % 4) == 1, i * 7 + 32'h50, "");
        end
        // R10: never two memory requests outstanding
        chk("R10", "overlapping memory requests", overlap, 0);
        done = 1;
    end
endmodule

// Top bench: runs all four write-policy builds side by side.
module setassoc_cache_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0] done;
    int errs [4];
    int chks [4];

    always #(CLK_PERIOD / 2) clk = ~clk;

    for (genvar g = 0; g < 4; g++) begin : g_run
        setassoc_cache_run #(.WA(g >= 2), .WB((g % 2) == 1)) u_run (
            .clk(clk), .rst_n(rst_n), .done(done[g]), .errors(errs[g]), .checks(chks[g])
        );
    end

    initial begin
        int n = 0, e = 0, c = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        while (!(&done) && n < WATCHDOG) begin @(posedge clk); n++; end
        #1;
        for (int i = 0; i < 4; i++) begin e += errs[i]; c += chks[i]; end
        if (!(&done)) begin
            e++; c++;
            $display("FAIL watchdog (all requirements): actual=%b expected=1111", done);
        end
        $display("Result: errors=%0d of %0d checks", e, c);
        $finish;
    end
endmodule